// File: doc/BRIEF.md
# Four-Round SM4 Vector Round Unit

This block runs four back-to-back SM4 rounds on a 128-bit state made of four 32-bit lanes. Lane 0 (bits 31:0) is the oldest word. One clock performs one round, so an operation takes four working cycles. A single mode bit picks one of two uses. In cipher mode the block encrypts data with four round keys. In key-schedule mode it derives four new round keys from four constants. The byte substitution and the word-level XOR network are shared by both modes. Only the linear diffusion step differs between them.

An operation starts with a one-cycle `start` pulse while the unit is idle. That edge latches all three operands and the mode. Three named states control the unit. ST_IDLE moves to ST_RUN when `start` is seen. ST_RUN stays in place for four rounds and then moves to ST_DONE after the last round. ST_DONE always returns to ST_IDLE on the next cycle. `busy` is high in ST_RUN. `done` is high in ST_DONE. `result` always shows the state register.

Top module: `sm4r_unit`

## Requirements
- R1: A `start` seen in ST_IDLE latches the operands and the mode. `busy` is then high for exactly the four cycles that follow that edge, one round per cycle.
- R2: `done` is high for exactly one cycle, directly after the cycle in which `busy` is last high, and `result` is valid in that cycle. `result` holds its value until the next accepted `start`.
- R3: When `key_mode` is 0 (cipher), the starting state is `dst_in` and the round word for round i is lane i of `src1_in`, in bits 32i+31:32i.
- R4: When `key_mode` is 1 (key schedule), the starting state is `src1_in` and the round word for round i is lane i of `src2_in`.
- R5: Each round forms the substitution input X = W1 ^ W2 ^ W3 ^ round word. Every byte of X goes through the byte substitution S, and the four outputs keep their byte positions. S is defined in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1 as S(b) = L(inv(L(b))), where inv(0) = 0 and L(x) = x ^ ror(x,1) ^ ror(x,2) ^ ror(x,5) ^ ror(x,7) ^ 0xD3. This gives S(0x00) = 0xD6. The table is stored in reverse, so byte b is read at address 255 - b.
- R6: In cipher mode the substituted word T is diffused to T ^ rotl(T,2) ^ rotl(T,10) ^ rotl(T,18) ^ rotl(T,24), all of them 32-bit left rotations.
- R7: In key-schedule mode T is diffused to T ^ rotl(T,13) ^ rotl(T,23).
- R8: The new word is the diffused word XOR W0. The lanes then shift down (W0 takes W1, W1 takes W2, W2 takes W3) and W3 takes the new word. After four rounds, lane 0 of `result` (bits 31:0) holds W0.
- R9: A `start` that arrives during ST_RUN or ST_DONE is ignored. The running operation's result is unchanged, and no extra `done` follows.
- R10: A synchronous active-high `rst` clears `result` to zero and drives `busy` and `done` low on the next cycle, including when it arrives in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| key_mode | input | 1 | 0 = cipher rounds, 1 = key-schedule rounds |
| dst_in | input | 128 | Destination operand (starting state in cipher mode) |
| src1_in | input | 128 | First source (round keys in cipher mode, starting state in key mode) |
| src2_in | input | 128 | Second source (constants in key mode) |
| busy | output | 1 | High while rounds are being computed |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 128 | Current 128-bit state, lane 0 in bits 31:0 |

## Verification
The embedded assertions check the control behaviour on every cycle: busy starts only after an idle start, done follows the fourth round, done never lasts two cycles, the lanes shift down on each round, the latched mode and result stay fixed when no load happens, and reset clears everything. The scenarios cover what only the computed data can show: the operand routing per mode, the byte substitution, both diffusion variants and the final lane order. These are checked against a separate model for all-zero, all-ones and mixed operands, together with starts injected during ST_RUN and ST_DONE and a reset in the middle of an operation.

// File: rtl/sm4r_pkg.sv
package sm4r_pkg;

    localparam int LANE_W  = 32;
    localparam int LANES   = 4;
    localparam int STATE_W = LANE_W * LANES;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = LANE_W / BYTE_W;
    localparam int ROM_DEPTH = 1 << BYTE_W;
    localparam int ROUNDS  = LANES;

    localparam logic [7:0] GF_REDUCE = 8'hF5;
    localparam logic [7:0] AFF_ROW   = 8'hA7;
    localparam logic [7:0] AFF_CONST = 8'hD3;

    localparam int ENC_ROT_A = 2;
    localparam int ENC_ROT_B = 10;
    localparam int ENC_ROT_C = 18;
    localparam int ENC_ROT_D = 24;
    localparam int KEY_ROT_A = 13;
    localparam int KEY_ROT_B = 23;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_t;

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        logic [15:0] dbl;
        dbl = {v, v};
        return dbl[15 - n -: 8];
    endfunction

    function automatic logic [LANE_W-1:0] rotl32(input logic [LANE_W-1:0] w, input int n);
        logic [2*LANE_W-1:0] dbl;
        dbl = {w, w};
        return dbl[2*LANE_W-1 - n -: LANE_W];
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[7] ? ({x[6:0], 1'b0} ^ GF_REDUCE) : {x[6:0], 1'b0};
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse; zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p;
        logic [7:0] r;
        p = a;
        r = 8'h01;
        for (int k = 1; k < 8; k++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] affine(input logic [7:0] x);
        logic [7:0] y;
        for (int i = 0; i < 8; i++) begin
            y[i] = ^(x & rotl8(AFF_ROW, i));
        end
        return y ^ AFF_CONST;
    endfunction

    function automatic logic [7:0] sbox_value(input logic [7:0] b);
        return affine(gf_inv(affine(b)));
    endfunction

endpackage

// File: rtl/sm4r_sbox_rom.sv
module sm4r_sbox_rom
    import sm4r_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out
);
    // contents kept in reverse order: entry a holds S(DEPTH-1-a)
    logic [BYTE_W-1:0] rom [ROM_DEPTH];
    logic [BYTE_W-1:0] addr;

    for (genvar a = 0; a < ROM_DEPTH; a++) begin : g_rom
        assign rom[a] = sbox_value(BYTE_W'(ROM_DEPTH - 1 - a));
    end

    assign addr     = BYTE_W'(ROM_DEPTH - 1) - byte_in;
    assign byte_out = rom[addr];

endmodule

// File: rtl/sm4r_round.sv
module sm4r_round
    import sm4r_pkg::*;
(
    input  logic               key_sel,
    input  logic [STATE_W-1:0] state_in,
    input  logic [LANE_W-1:0]  round_word,
    output logic [STATE_W-1:0] state_out
);
    logic [LANE_W-1:0] w0, w1, w2, w3;
    logic [LANE_W-1:0] mix_in;
    logic [LANE_W-1:0] subst;
    logic [LANE_W-1:0] diff_enc;
    logic [LANE_W-1:0] diff_key;
    logic [LANE_W-1:0] fresh;

    assign w0 = state_in[0*LANE_W +: LANE_W];
    assign w1 = state_in[1*LANE_W +: LANE_W];
    assign w2 = state_in[2*LANE_W +: LANE_W];
    assign w3 = state_in[3*LANE_W +: LANE_W];

    assign mix_in = w1 ^ w2 ^ w3 ^ round_word;

    for (genvar b = 0; b < NBYTES; b++) begin : g_sub
        sm4r_sbox_rom u_rom (
            .byte_in  (mix_in[b*BYTE_W +: BYTE_W]),
            .byte_out (subst[b*BYTE_W +: BYTE_W])
        );
    end

    assign diff_enc = subst ^ rotl32(subst, ENC_ROT_A) ^ rotl32(subst, ENC_ROT_B)
                    ^ rotl32(subst, ENC_ROT_C) ^ rotl32(subst, ENC_ROT_D);
    assign diff_key = subst ^ rotl32(subst, KEY_ROT_A) ^ rotl32(subst, KEY_ROT_B);

    assign fresh     = (key_sel ? diff_key : diff_enc) ^ w0;
    assign state_out = {fresh, state_in[STATE_W-1:LANE_W]};

endmodule

// File: rtl/sm4r_ctrl.sv
module sm4r_ctrl
    import sm4r_pkg::*;
#(
    parameter int NROUNDS = ROUNDS,
    localparam int RND_W = (NROUNDS > 1) ? $clog2(NROUNDS) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic             done,
    output logic [RND_W-1:0] rnd
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NROUNDS - 1);

    ctrl_state_t state_q, state_d;

    // state register and round counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rnd     <= '0;
        end else begin
            state_q <= state_d;
            if (load)      rnd <= '0;
            else if (step) rnd <= rnd + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (rnd == LAST_RND) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    a_r1_last_round_done: assert property (@(posedge clk) disable iff (rst)
        (busy && rnd == LAST_RND) |=> (done && !busy));
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/sm4r_unit.sv
module sm4r_unit
    import sm4r_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               key_mode,
    input  logic [STATE_W-1:0] dst_in,
    input  logic [STATE_W-1:0] src1_in,
    input  logic [STATE_W-1:0] src2_in,
    output logic               busy,
    output logic               done,
    output logic [STATE_W-1:0] result
);
    localparam int RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

    logic               load, step;
    logic [RND_W-1:0]   rnd;
    logic               mode_q;
    logic [STATE_W-1:0] st_q, st_nxt;
    logic [STATE_W-1:0] rk_q;
    logic [LANE_W-1:0]  rk_word;

    sm4r_ctrl #(.NROUNDS(ROUNDS)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done),
        .rnd   (rnd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            rk_q   <= '0;
            mode_q <= 1'b0;
        end else if (load) begin
            st_q   <= key_mode ? src1_in : dst_in;
            rk_q   <= key_mode ? src2_in : src1_in;
            mode_q <= key_mode;
        end else if (step) begin
            st_q   <= st_nxt;
        end
    end

    assign rk_word = rk_q[int'(rnd)*LANE_W +: LANE_W];

    sm4r_round u_round (
        .key_sel    (mode_q),
        .state_in   (st_q),
        .round_word (rk_word),
        .state_out  (st_nxt)
    );

    assign result = st_q;

    a_r8_lane_shift: assert property (@(posedge clk) disable iff (rst)
        busy |=> (result[STATE_W-LANE_W-1:0] == $past(result[STATE_W-1:LANE_W])));
    a_r2_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> $stable(result));
    a_r9_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (busy || done) |=> $stable(mode_q));
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (result == '0 && !busy && !done));

endmodule

// File: tb/sm4r_unit_tb.sv
`timescale 1ns/1ps
module sm4r_unit_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         key_mode = 1'b0;
    logic [127:0] dst_in = '0;
    logic [127:0] src1_in = '0;
    logic [127:0] src2_in = '0;
    logic         busy, done;
    logic [127:0] result;

    int n_chk = 0;
    int n_fail = 0;
    int issued = 0;
    int seen_done = 0;
    logic [127:0] exp_q [$];
    logic         mode_q [$];
    logic [7:0]   sb [256];

    always #10 clk = ~clk;

    sm4r_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .key_mode(key_mode),
        .dst_in(dst_in), .src1_in(src1_in), .src2_in(src2_in),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // independent model of the substitution (R5)
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h1F5 << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_ror(input logic [7:0] x, input int n);
        return (x >> n) | (x << (8 - n));
    endfunction

    function automatic logic [7:0] m_lin(input logic [7:0] x);
        return x ^ m_ror(x, 1) ^ m_ror(x, 2) ^ m_ror(x, 5) ^ m_ror(x, 7) ^ 8'hD3;
    endfunction

    function automatic logic [31:0] m_rl(input logic [31:0] t, input int n);
        return (t << n) | (t >> (32 - n));
    endfunction

    function automatic logic [127:0] ref_op(input logic m, input logic [127:0] d,
                                            input logic [127:0] s1, input logic [127:0] s2);
        logic [31:0] w [4];
        logic [127:0] keys;
        for (int i = 0; i < 4; i++) w[i] = m ? s1[32*i +: 32] : d[32*i +: 32];
        keys = m ? s2 : s1;
        for (int r = 0; r < 4; r++) begin
            logic [31:0] x, t, nw;
            x = w[1] ^ w[2] ^ w[3] ^ keys[32*r +: 32];
            t = {sb[x[31:24]], sb[x[23:16]], sb[x[15:8]], sb[x[7:0]]};
            if (m) t = t ^ m_rl(t, 13) ^ m_rl(t, 23);
            else   t = t ^ m_rl(t, 2) ^ m_rl(t, 10) ^ m_rl(t, 18) ^ m_rl(t, 24);
            nw = t ^ w[0];
            w[0] = w[1]; w[1] = w[2]; w[2] = w[3]; w[3] = nw;
        end
        return {w[3], w[2], w[1], w[0]};
    endfunction

    // monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            seen_done++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", result, '0);
            end else begin
                logic [127:0] e;
                logic m;
                e = exp_q.pop_front();
                m = mode_q.pop_front();
                if (m) check(result === e, "R4 R5 R7 R8 key-schedule result", result, e);
                else   check(result === e, "R3 R5 R6 R8 cipher result", result, e);
            end
        end
    end

    task automatic run_op(input logic m, input logic [127:0] d, input logic [127:0] s1,
                          input logic [127:0] s2, input bit poke);
        logic [127:0] e;
        e = ref_op(m, d, s1, s2);
        exp_q.push_back(e);
        mode_q.push_back(m);
        issued++;
        @(negedge clk);
        key_mode = m; dst_in = d; src1_in = s1; src2_in = s2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 4; c++) begin
            check(busy === 1'b1 && done === 1'b0, "R1 busy during rounds",
                  128'(busy), 128'(1));
            if (poke && c == 1) begin
                start = 1'b1; key_mode = ~m; dst_in = ~d; src1_in = ~s1; src2_in = s2 ^ 128'h5A5A;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(done === 1'b1 && busy === 1'b0, "R2 done after four rounds", 128'(done), 128'(1));
        if (poke) begin
            start = 1'b1; key_mode = m; dst_in = s2; src1_in = d; src2_in = s1;
        end
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b0, "R2 done lasts one cycle", 128'(done), 128'(0));
        check(result === e, "R2 result held after done", result, e);
        if (poke) check(busy === 1'b0, "R9 start ignored while busy or done", 128'(busy), 128'(0));
        @(negedge clk);
        check(result === e && busy === 1'b0, "R9 R2 no new operation", result, e);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < 256; b++) begin
            logic [7:0] y, inv;
            y = m_lin(8'(b));
            inv = 8'h00;
            for (int c = 1; c < 256; c++) if (m_mul(y, 8'(c)) == 8'h01) inv = 8'(c);
            sb[b] = m_lin(inv);
        end
        check(sb[0] === 8'hD6, "R5 model substitution of zero", 128'(sb[0]), 128'hD6);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(result === '0 && busy === 1'b0 && done === 1'b0, "R10 reset state", result, '0);

        run_op(1'b0, '0, '0, '0, 1'b0);
        run_op(1'b1, '0, '0, '0, 1'b0);
        run_op(1'b0, '1, '1, '1, 1'b0);
        run_op(1'b1, '1, '1, '1, 1'b0);
        run_op(1'b0, 128'h0123456789ABCDEFFEDCBA9876543210,
                     128'hF12186F9_41662B61_5A6AB19A_7BA92077, '0, 1'b0);
        run_op(1'b1, 128'hDEADBEEF_00000000_13579BDF_FFFFFFFF,
                     128'h0123456789ABCDEFFEDCBA9876543210,
                     128'h546D7A81_383F464D_1C232A31_00070E15, 1'b0);
        run_op(1'b0, 128'h00000001_00000002_00000004_00000008,
                     128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0, '1, 1'b1);
        run_op(1'b1, 128'hCAFEF00D_CAFEF00D_CAFEF00D_CAFEF00D,
                     128'h11111111_22222222_33333333_44444444,
                     128'h80000000_00000001_7FFFFFFF_FFFFFFFE, 1'b1);

        // reset in the middle of an operation
        @(negedge clk);
        key_mode = 1'b0; dst_in = '1; src1_in = 128'h1234; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(result === '0 && busy === 1'b0 && done === 1'b0, "R10 reset mid-operation",
              result, '0);
        repeat (6) @(negedge clk);
        check(busy === 1'b0 && result === '0, "R10 no activity after reset", result, '0);

        run_op(1'b0, 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0, '0,
                     128'h1, 1'b0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && seen_done == issued, "R9 one done per accepted start",
              128'(seen_done), 128'(issued));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule